// File: doc/BRIEF.md
# Decoded Twisted-Ring Decade Divider

This block divides its clock by ten. It holds its count in a five-bit twisted-ring (Johnson) register and decodes that code into ten slot lines. Exactly one slot line is high at a time, and the active line steps up one position on every clock edge that is not inhibited. A carry line is high for the first half of each ten-count cycle and low for the second half. Its rising edge marks the wrap to count zero, so it can clock a following stage in a ripple chain.

An active-high synchronous clear forces count zero. An active-high inhibit input freezes the count; the divider advances only while inhibit is 0. The next-state logic is self-correcting. Any five-bit pattern outside the ten legal codes is replaced by the zero-count code on the next clock edge, so the ring cannot remain in a stray state. Both the slot lines and the carry are registered. The stage count is a parameter; with four stages the block becomes a divide-by-eight.

Top module: `twr_decade_divider`

## Requirements
- R1: When clr is 1 at a rising clock edge, slot_q becomes 10'b0000000001 and carry_o becomes 1 after that edge, whatever the value of inhibit.
- R2: From the first edge with clr set onwards, slot_q has exactly one bit set at every edge.
- R3: When inhibit is 1 and clr is 0 at an edge, slot_q and carry_o keep their values across that edge.
- R4: When inhibit is 0 and clr is 0 at an edge, the set bit of slot_q moves from position k to position k+1, and from position 9 back to position 0.
- R5: carry_o is 1 while the count (the index of the set slot bit) is 0 to 4, and 0 while it is 5 to 9. It therefore rises exactly when the count wraps to 0, and one carry period spans ten uninhibited edges.
- R6: The five-bit ring code for count k is as follows. For k from 0 to 5, the low k bits are 1 and the rest are 0. For k = 5+j with j from 1 to 4, the low j bits are 0 and the rest are 1. The next-state unit twr_next maps a legal code to the code of count k+1 (mod 10) when inhibit is 0, and to the same code when inhibit is 1.
- R7: The next-state unit twr_next maps each of the 22 illegal five-bit patterns to the count-0 code 00000 in a single step, whatever the value of inhibit. It maps any pattern to 00000 when clr is 1.
- R8: Every legal ring code seen by the register has at most one bit change between neighbouring stages. The slot lines are derived from pairs of adjacent stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr | input | 1 | Synchronous clear to count 0, active high, overrides inhibit |
| inhibit | input | 1 | Active-high count freeze; counting proceeds when 0 |
| slot_q | output | 10 | Registered one-hot decoded count |
| carry_o | output | 1 | Registered carry, high for counts 0 to 4 |

## Verification
The hardest case to bring about is an illegal ring pattern. A clear or any sequence of clocks from the ports only ever produces the ten legal codes, so the recovery path cannot be reached through the top-level ports. The bench therefore drives the next-state unit on its own, applying all 32 five-bit patterns with each value of inhibit and clear, and compares each result with a code table built from the R6 encoding. The top itself gets random mixes of clear and inhibit against a counting model, with directed runs for a clear that coincides with inhibit, long holds and full carry periods.

// File: rtl/twr_pkg.sv
package twr_pkg;

  // Kind of step the ring register takes on the next edge.
  typedef enum logic [1:0] {
    STEP_CLEAR = 2'd0,
    STEP_MEND  = 2'd1,
    STEP_HOLD  = 2'd2,
    STEP_SHIFT = 2'd3
  } step_t;

endpackage

// File: rtl/twr_next.sv
module twr_next
  import twr_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0] state_i,
  input  logic              clr_i,
  input  logic              inhibit_i,
  output logic [STAGES-1:0] next_o
);

  localparam int EDGES = STAGES - 1;

  logic [EDGES-1:0] flips;
  logic             legal;
  step_t            step;

  // A legal twisted-ring code has at most one change between neighbours.
  assign flips = state_i[STAGES-1:1] ^ state_i[STAGES-2:0];
  assign legal = ($countones(flips) <= 1);

  always_comb begin
    if (clr_i)          step = STEP_CLEAR;
    else if (!legal)    step = STEP_MEND;
    else if (inhibit_i) step = STEP_HOLD;
    else                step = STEP_SHIFT;
  end

  always_comb begin
    unique case (step)
      STEP_CLEAR: next_o = '0;
      STEP_MEND:  next_o = '0;
      STEP_HOLD:  next_o = state_i;
      default:    next_o = {state_i[STAGES-2:0], ~state_i[STAGES-1]};
    endcase
  end

endmodule

// File: rtl/twr_decode.sv
module twr_decode #(
  parameter int STAGES = 5
) (
  input  logic [STAGES-1:0]   ring_i,
  output logic [2*STAGES-1:0] slot_o,
  output logic                carry_o
);

  // Each slot reads two adjacent stages, so one stage change per step
  // moves exactly one slot decision.
  for (genvar k = 0; k < STAGES; k++) begin : g_slot
    if (k == 0) begin : g_ends
      assign slot_o[0]      = ~ring_i[STAGES-1] & ~ring_i[0];
      assign slot_o[STAGES] =  ring_i[STAGES-1] &  ring_i[0];
    end else begin : g_mid
      assign slot_o[k]        =  ring_i[k-1] & ~ring_i[k];
      assign slot_o[STAGES+k] = ~ring_i[k-1] &  ring_i[k];
    end
  end

  assign carry_o = ~ring_i[STAGES-1];

endmodule

// File: rtl/twr_decade_divider.sv
module twr_decade_divider #(
  parameter int STAGES = 5
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                inhibit,
  output logic [2*STAGES-1:0] slot_q,
  output logic                carry_o
);

  localparam int SLOTS = 2 * STAGES;

  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_d;
  logic [SLOTS-1:0]  slot_d;
  logic              carry_d;

  twr_next #(.STAGES(STAGES)) i_next (
    .state_i   (ring_q),
    .clr_i     (clr),
    .inhibit_i (inhibit),
    .next_o    (ring_d)
  );

  // Decode the next code so the registered slots line up with the ring.
  twr_decode #(.STAGES(STAGES)) i_decode (
    .ring_i  (ring_d),
    .slot_o  (slot_d),
    .carry_o (carry_d)
  );

  always_ff @(posedge clk) begin
    ring_q  <= ring_d;
    slot_q  <= slot_d;
    carry_o <= carry_d;
  end

  // R1: clear wins over inhibit and lands on count 0
  a_r1_clear: assert property (@(posedge clk)
    clr |=> (slot_q == SLOTS'(1)) && carry_o);

  // R2: one slot active at a time
  a_r2_onehot: assert property (@(posedge clk) disable iff (clr)
    $countones(slot_q) == 1);

  // R3: inhibit freezes the outputs
  a_r3_hold: assert property (@(posedge clk) disable iff (clr)
    inhibit |=> $stable(slot_q) && $stable(carry_o));

  // R4: an uninhibited edge rotates the active slot up by one
  a_r4_step: assert property (@(posedge clk) disable iff (clr)
    !inhibit |=> slot_q == {$past(slot_q[SLOTS-2:0]), $past(slot_q[SLOTS-1])});

  // R5: carry rises only on the wrap to count 0
  a_r5_carry_wrap: assert property (@(posedge clk) disable iff (clr)
    $rose(carry_o) |-> slot_q[0]);

  // R8: the ring only ever holds codes with a single neighbour change
  a_r8_ring_legal: assert property (@(posedge clk) disable iff (clr)
    $countones(ring_q[STAGES-1:1] ^ ring_q[STAGES-2:0]) <= 1);

endmodule

// File: tb/test_twr_decade_divider.sv
`timescale 1ns / 100ps
module test_twr_decade_divider;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       inhibit = 1'b0;
  logic [9:0] slot_q;
  logic       carry_o;

  logic [4:0] m_state;
  logic       m_clr;
  logic       m_inh;
  logic [4:0] m_next;

  int total = 0;
  int bad   = 0;
  int exp_count = 0;

  always #2.5 clk = ~clk;

  twr_decade_divider i_twr_decade_divider (
    .clk     (clk),
    .clr     (clr),
    .inhibit (inhibit),
    .slot_q  (slot_q),
    .carry_o (carry_o)
  );

  twr_next #(.STAGES(5)) i_twr_next (
    .state_i   (m_state),
    .clr_i     (m_clr),
    .inhibit_i (m_inh),
    .next_o    (m_next)
  );

  // Ring code of count k as stated in R6.
  function automatic logic [4:0] code_of(input int k);
    logic [4:0] c;
    c = '0;
    for (int b = 0; b < 5; b++) begin
      if (k <= 5) c[b] = (b < k);
      else        c[b] = (b >= k - 5);
    end
    return c;
  endfunction

  function automatic int count_of(input logic [4:0] c);
    for (int k = 0; k < 10; k++) if (code_of(k) == c) return k;
    return -1;
  endfunction

  task automatic check_outputs(input string req);
    logic [9:0] es;
    logic       ec;
    es = 10'(1) << exp_count;
    ec = (exp_count < 5);
    total++;
    if (slot_q !== es) begin
      bad++;
      $display("FAIL %s slot_q actual=%b expected=%b", req, slot_q, es);
    end
    total++;
    if (carry_o !== ec) begin
      bad++;
      $display("FAIL R5 carry_o actual=%b expected=%b (count %0d)", carry_o, ec, exp_count);
    end
    total++;
    if ($countones(slot_q) != 1) begin
      bad++;
      $display("FAIL R2 slot_q actual=%b expected one bit set", slot_q);
    end
  endtask

  // Apply inputs after a falling edge, let one rising edge pass, check.
  task automatic step(input logic c, input logic inh, input string req);
    clr = c;
    inhibit = inh;
    if (c) exp_count = 0;
    else if (!inh) exp_count = (exp_count + 1) % 10;
    @(negedge clk);
    check_outputs(req);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_state = '0; m_clr = 1'b0; m_inh = 1'b0;
    @(negedge clk);
    step(1'b1, 1'b1, "R1 clear with inhibit");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R4 advance");
    step(1'b1, 1'b1, "R1 clear mid-count with inhibit");
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, "R4 advance");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R3 hold");
    // R5: two full carry periods, including wrap from slot 9 to slot 0
    for (int i = 0; i < 20; i++) begin
      logic prev_c;
      prev_c = carry_o;
      step(1'b0, 1'b0, "R4 wrap run");
      if (!prev_c && carry_o) begin
        total++;
        if (exp_count != 0) begin
          bad++;
          $display("FAIL R5 carry rose at count actual=%0d expected=0", exp_count);
        end
      end
    end
    // Random mix of clear, inhibit and counting.
    for (int i = 0; i < 3000; i++) begin
      logic c, h;
      c = ($urandom_range(0, 29) == 0);
      h = ($urandom_range(0, 2) == 0);
      step(c, h, c ? "R1 random clear" : (h ? "R3 random hold" : "R4 random step"));
    end
    // Next-state unit over all 32 patterns (R6, R7).
    for (int p = 0; p < 32; p++) begin
      for (int mode = 0; mode < 3; mode++) begin
        logic [4:0] e;
        int         k;
        m_state = 5'(p);
        m_clr   = (mode == 2);
        m_inh   = (mode == 1);
        #1;
        k = count_of(5'(p));
        if (mode == 2)   e = '0;
        else if (k < 0)  e = '0;
        else if (m_inh)  e = code_of(k);
        else             e = code_of((k + 1) % 10);
        total++;
        if (m_next !== e) begin
          bad++;
          $display("FAIL %s pattern=%b inh=%b clr=%b actual=%b expected=%b",
                   (k < 0 || mode == 2) ? "R7" : "R6", 5'(p), m_inh, m_clr, m_next, e);
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule